// File: doc/BRIEF.md
# Interrupt Status Queue Writer

This block records interrupt events as two-word entries in a circular queue kept in shared RAM. Each entry begins with a vector word. Its bit 0 tells a message event from a non-message event, and a one-hot code names which non-message event occurred. A parameter word follows the vector word. For a message event it points at the block status word of a command stack descriptor. For a RAM parity error it holds the failing RAM address. For every other event it is zero.

Events arrive as one-cycle pulses and are held in sticky pending flags. A pending flag stays set until its entry is written, so an event that arrives while an entry is being written is not lost. Pending events are served one at a time in a fixed priority. The block writes through a plain single-port memory write interface and advances a queue pointer that stays inside one 64-word aligned region. When its enable input is high, the block pulses a rollover interrupt each time the pointer wraps back to the start of that region.

Top module: `isq_writer`

## Requirements
- R1: After reset, `mem_we` is 0, `roll_irq` is 0 and `queue_ptr` equals the parameter `QBASE` (0x0100 by default).
- R2: For each entry, the vector word is written at `queue_ptr`, and in the next cycle the parameter word is written at `queue_ptr`+1. The vector write is visible in the cycle right after the clock edge that samples the event pulse, when no other entry is in progress.
- R3: A message entry has the vector word 0x0001 (bit 0 set), and its parameter word is the descriptor pointer sampled with `msg_evt`.
- R4: A non-message entry has bit 0 clear and exactly one code bit set: bit 1 for time tag rollover, bit 2 for RT address parity error, bit 3 for RAM parity error and bit 4 for self-test complete. All other bits are 0.
- R5: The parameter word of a RAM parity entry is `ram_err_addr` sampled with the event. The parameter word of time tag rollover, RT address parity and self-test entries is 0x0000.
- R6: Events raised in the same cycle give separate entries in the order message, time tag, RT address parity, RAM parity, self-test. Events raised while an entry is being written are held and written later.
- R7: After each entry, `queue_ptr` advances by 2. Its low 6 bits wrap from 62 to 0 and its upper bits never change.
- R8: In the cycle after the parameter word is written at region offset 63, `roll_irq` is high for exactly one cycle if `roll_en` is 1. Otherwise `roll_irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_evt | input | 1 | Message event pulse |
| msg_desc_ptr | input | 16 | Descriptor pointer carried by a message event |
| ttag_roll_evt | input | 1 | Time tag rollover event pulse |
| rtaddr_par_evt | input | 1 | RT address parity error event pulse |
| ram_par_evt | input | 1 | RAM parity error event pulse |
| ram_err_addr | input | 16 | Failing RAM address carried by a RAM parity event |
| selftest_evt | input | 1 | Self-test complete event pulse |
| roll_en | input | 1 | Enables the queue rollover interrupt |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 16 | Memory write data |
| queue_ptr | output | 16 | Address where the next entry will be written |
| roll_irq | output | 1 | One-cycle queue rollover interrupt |

## Verification
An event pulse is sampled at one edge. The vector write shows on the memory port one cycle later, the parameter write one cycle after that, and `roll_irq` one cycle after the parameter write that ends a lap. The bench drives inputs and samples outputs on the falling edge. It pushes each expected (address, data) pair into a scoreboard queue, and a monitor compares every write strobe against the head of that queue. A roll-interrupt expectation is armed from the observed offset-63 parameter write and checked at the very next falling edge, so any shift in latency shows up as a mismatch.

// File: rtl/isq_pkg.sv
package isq_pkg;

    parameter int AW = 16;
    parameter int DW = 16;
    parameter int NSRC = 5;
    parameter int REGION_BITS = 6;

    localparam int SRC_MSG    = 0;
    localparam int SRC_TTAG   = 1;
    localparam int SRC_RTADDR = 2;
    localparam int SRC_RAMPAR = 3;
    localparam int SRC_SELF   = 4;

    typedef enum logic {
        PH_VEC   = 1'b0,
        PH_PARAM = 1'b1
    } phase_e;

    typedef struct packed {
        logic [NSRC-1:0] flag;
        logic [AW-1:0]   msg_ptr;
        logic [AW-1:0]   err_addr;
    } pend_t;

    function automatic logic [DW-1:0] vec_word(input logic [NSRC-1:0] onehot);
        logic [DW-1:0] w;
        w = '0;
        w[NSRC-1:0] = onehot;
        return w;
    endfunction

    function automatic logic [NSRC-1:0] pick_first(input logic [NSRC-1:0] req);
        logic [NSRC-1:0] g;
        g = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                g = '0;
                g[i] = 1'b1;
            end
        end
        return g;
    endfunction

endpackage

// File: rtl/isq_pending.sv
module isq_pending
    import isq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] raise,
    input  logic [AW-1:0]   msg_ptr_in,
    input  logic [AW-1:0]   err_addr_in,
    input  logic [NSRC-1:0] grant,
    output pend_t           pend
);

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                pend.flag[i] <= 1'b0;
            else if (raise[i])
                pend.flag[i] <= 1'b1;
            else if (grant[i])
                pend.flag[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend.msg_ptr  <= '0;
            pend.err_addr <= '0;
        end else begin
            if (raise[SRC_MSG])
                pend.msg_ptr <= msg_ptr_in;
            if (raise[SRC_RAMPAR])
                pend.err_addr <= err_addr_in;
        end
    end

    // R6: a raised event is pending at the next edge
    a_r6_event_held: assert property (@(posedge clk) disable iff (rst)
        (raise != '0) |=> ((pend.flag & $past(raise)) == $past(raise)));

endmodule

// File: rtl/isq_seq.sv
module isq_seq
    import isq_pkg::*;
#(
    parameter logic [AW-1:0] QBASE = 16'h0100
) (
    input  logic            clk,
    input  logic            rst,
    input  pend_t           pend,
    input  logic            roll_en,
    output logic [NSRC-1:0] grant,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [AW-1:0]   ptr,
    output logic            roll_irq,
    output logic            vec_phase
);

    localparam int OFFW = REGION_BITS;

    phase_e        phase;
    logic [DW-1:0] param_q;
    logic [NSRC-1:0] pick;
    logic [DW-1:0] param_sel;
    logic [OFFW-1:0] next_off;
    logic          wrap;

    assign pick = pick_first(pend.flag);

    always_comb begin
        param_sel = '0;
        if (pick[SRC_MSG])
            param_sel = DW'(pend.msg_ptr);
        else if (pick[SRC_RAMPAR])
            param_sel = DW'(pend.err_addr);
    end

    assign grant     = (phase == PH_VEC) ? pick : '0;
    assign vec_phase = (phase == PH_VEC) && (pick != '0);
    assign mem_we    = vec_phase || (phase == PH_PARAM);
    assign mem_addr  = (phase == PH_PARAM) ? (ptr | AW'(1)) : ptr;
    assign mem_wdata = (phase == PH_PARAM) ? param_q : vec_word(pick);
    assign next_off  = ptr[OFFW-1:0] + OFFW'(2);
    assign wrap      = (next_off == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_VEC;
            param_q  <= '0;
            ptr      <= QBASE;
            roll_irq <= 1'b0;
        end else begin
            roll_irq <= 1'b0;
            if (phase == PH_PARAM) begin
                phase <= PH_VEC;
                ptr   <= {ptr[AW-1:OFFW], next_off};
                roll_irq <= wrap && roll_en;
            end else if (pick != '0) begin
                phase   <= PH_PARAM;
                param_q <= param_sel;
            end
        end
    end

    // R2: parameter word follows the vector word at the next address
    a_r2_param_next: assert property (@(posedge clk) disable iff (rst)
        vec_phase |=> (mem_we && !vec_phase && mem_addr == $past(mem_addr) + AW'(1)));

    // R4: at most one event tag per vector word
    a_r4_one_tag: assert property (@(posedge clk) disable iff (rst)
        vec_phase |-> ($countones(mem_wdata[NSRC-1:0]) == 1 && mem_wdata[DW-1:NSRC] == '0));

    // R7: pointer stays even and inside its region
    a_r7_ptr_region: assert property (@(posedge clk) disable iff (rst)
        (ptr[0] == 1'b0 && ptr[AW-1:OFFW] == QBASE[AW-1:OFFW]));

    // R8: rollover pulse lasts one cycle and needs the enable
    a_r8_roll_pulse: assert property (@(posedge clk) disable iff (rst)
        roll_irq |=> !roll_irq);
    a_r8_roll_enabled: assert property (@(posedge clk) disable iff (rst)
        roll_irq |-> $past(roll_en));

endmodule

// File: rtl/isq_writer.sv
module isq_writer
    import isq_pkg::*;
#(
    parameter logic [AW-1:0] QBASE = 16'h0100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          msg_evt,
    input  logic [AW-1:0] msg_desc_ptr,
    input  logic          ttag_roll_evt,
    input  logic          rtaddr_par_evt,
    input  logic          ram_par_evt,
    input  logic [AW-1:0] ram_err_addr,
    input  logic          selftest_evt,
    input  logic          roll_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] queue_ptr,
    output logic          roll_irq
);

    logic [NSRC-1:0] raise;
    logic [NSRC-1:0] grant;
    pend_t           pend;
    logic            vec_phase;

    always_comb begin
        raise = '0;
        raise[SRC_MSG]    = msg_evt;
        raise[SRC_TTAG]   = ttag_roll_evt;
        raise[SRC_RTADDR] = rtaddr_par_evt;
        raise[SRC_RAMPAR] = ram_par_evt;
        raise[SRC_SELF]   = selftest_evt;
    end

    isq_pending u_pend (
        .clk        (clk),
        .rst        (rst),
        .raise      (raise),
        .msg_ptr_in (msg_desc_ptr),
        .err_addr_in(ram_err_addr),
        .grant      (grant),
        .pend       (pend)
    );

    isq_seq #(.QBASE(QBASE)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .pend     (pend),
        .roll_en  (roll_en),
        .grant    (grant),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .ptr      (queue_ptr),
        .roll_irq (roll_irq),
        .vec_phase(vec_phase)
    );

    // R3: message vector word carries bit 0 only
    a_r3_msg_tag: assert property (@(posedge clk) disable iff (rst)
        (vec_phase && mem_wdata[0]) |-> (mem_wdata == DW'(1)));

endmodule

// File: tb/sim_isq_writer.sv
module sim_isq_writer;
    import isq_pkg::*;

    localparam logic [15:0] BASE = 16'h0100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic msg_evt = 0, ttag_roll_evt = 0, rtaddr_par_evt = 0, ram_par_evt = 0, selftest_evt = 0;
    logic [15:0] msg_desc_ptr = '0, ram_err_addr = '0;
    logic roll_en = 0;
    logic mem_we, roll_irq;
    logic [15:0] mem_addr, mem_wdata, queue_ptr;

    int errors = 0;
    int checks = 0;
    int roll_seen = 0;
    logic [15:0] model_ptr = BASE;
    logic [31:0] expq[$];
    logic roll_due = 0;

    always #10 clk = ~clk;

    isq_writer #(.QBASE(BASE)) u0 (
        .clk(clk), .rst(rst),
        .msg_evt(msg_evt), .msg_desc_ptr(msg_desc_ptr),
        .ttag_roll_evt(ttag_roll_evt), .rtaddr_par_evt(rtaddr_par_evt),
        .ram_par_evt(ram_par_evt), .ram_err_addr(ram_err_addr),
        .selftest_evt(selftest_evt), .roll_en(roll_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .queue_ptr(queue_ptr), .roll_irq(roll_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // push expected vector and parameter writes; R7 pointer model
    task automatic push_entry(input logic [15:0] vec, input logic [15:0] prm);
        expq.push_back({model_ptr, vec});
        expq.push_back({model_ptr + 16'd1, prm});
        model_ptr = {model_ptr[15:6], model_ptr[5:0] + 6'd2};
    endtask

    task automatic drain();
        for (int i = 0; i < 400 && expq.size() != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R6 queue drained", 32'(expq.size()), 32'd0);
        chk("R7 pointer", 32'(queue_ptr), 32'(model_ptr));
    endtask

    // monitor: compare each write with scoreboard head (R2..R6), roll timing (R8)
    always @(negedge clk) begin
        if (!rst) begin
            chk("R8 roll_irq", 32'(roll_irq), 32'(roll_due));
            if (roll_irq) roll_seen++;
            roll_due = 1'b0;
            if (mem_we) begin
                if (expq.size() == 0) begin
                    chk("R6 unexpected write", {mem_addr, mem_wdata}, 32'hFFFFFFFF);
                end else begin
                    chk("R2-write R3 R4 R5", {mem_addr, mem_wdata}, expq.pop_front());
                end
                if (mem_addr[0] && mem_addr[5:0] == 6'd63) roll_due = roll_en;
            end
        end
    end

    task automatic pulse(input logic [4:0] which, input logic [15:0] mp, input logic [15:0] ea);
        msg_evt = which[0]; ttag_roll_evt = which[1]; rtaddr_par_evt = which[2];
        ram_par_evt = which[3]; selftest_evt = which[4];
        msg_desc_ptr = mp; ram_err_addr = ea;
        @(negedge clk);
        msg_evt = 0; ttag_roll_evt = 0; rtaddr_par_evt = 0; ram_par_evt = 0; selftest_evt = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 mem_we", 32'(mem_we), 32'd0);
        chk("R1 roll_irq", 32'(roll_irq), 32'd0);
        chk("R1 queue_ptr", 32'(queue_ptr), 32'(BASE));

        // R2 latency: vector write exactly one cycle after the sampling edge
        pulse(5'b00001, 16'h1234, 16'h0);
        chk("R2 vector latency", {31'd0, mem_we}, 32'd1);
        push_entry(16'h0001, 16'h1234);   // R3
        drain();

        // R4 R5 non-message events one by one
        pulse(5'b00010, 16'h0, 16'hBEEF); push_entry(16'h0002, 16'h0000); drain();
        pulse(5'b00100, 16'h0, 16'hBEEF); push_entry(16'h0004, 16'h0000); drain();
        pulse(5'b01000, 16'h0, 16'h0ABC); push_entry(16'h0008, 16'h0ABC); drain();
        pulse(5'b10000, 16'h0, 16'hBEEF); push_entry(16'h0010, 16'h0000); drain();

        // R6 all at once: fixed priority, separate entries
        push_entry(16'h0001, 16'h4444);
        push_entry(16'h0002, 16'h0000);
        push_entry(16'h0004, 16'h0000);
        push_entry(16'h0008, 16'h5555);
        push_entry(16'h0010, 16'h0000);
        pulse(5'b11111, 16'h4444, 16'h5555);
        drain();

        // R6 events arriving during a write are held
        push_entry(16'h0008, 16'h0777);
        push_entry(16'h0001, 16'h0888);
        push_entry(16'h0010, 16'h0000);
        pulse(5'b01000, 16'h0, 16'h0777);
        pulse(5'b00001, 16'h0888, 16'h0);
        pulse(5'b10000, 16'h0, 16'h0);
        drain();

        // R7 R8 wrap with enable off: no rollover pulse
        roll_en = 1'b0;
        for (int i = 0; i < 34; i++) begin
            push_entry(16'h0002, 16'h0000);
            pulse(5'b00010, 16'h0, 16'h0);
            repeat (2) @(negedge clk);
        end
        drain();
        chk("R8 no roll when disabled", 32'(roll_seen), 32'd0);

        // R8 wrap with enable on: one pulse per lap
        roll_en = 1'b1;
        for (int i = 0; i < 34; i++) begin
            push_entry(16'h0001, 16'(i));
            pulse(5'b00001, 16'(i), 16'h0);
            repeat (2) @(negedge clk);
        end
        drain();
        chk("R8 one roll per lap", 32'(roll_seen), 32'd1);
        chk("R7 region kept", 32'(queue_ptr[15:6]), 32'(BASE[15:6]));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule